// File: doc/BRIEF.md
# Fine-Scroll Planar Pixel Shifter

This block turns groups of fetched bitplane words into a stream of per-pixel colour indices, one pixel per clock while display is enabled. A fetch group holds one 16-bit word per plane. In the four-plane mode all four words are used and each pixel gets a 4-bit index. In the one-plane mode only the lowest word is used and each pixel gets a 1-bit index.

A 4-bit scroll value is captured at each line start. It shifts the line left by 0 to 15 pixels. The leading pixels of the first group are dropped, and the right edge of the line is filled from one extra group that the fetch side supplies. With a scroll of zero no extra group is read, and the line looks exactly like an unscrolled one. For the fetch logic, the block reports how many groups the current line takes.

Each plane holds a two-word window (current and next) and one staging word. The fetch side loads two groups after line start to prime the window. After that it loads each further group at some point during the 16 pixels that come before that group is needed.

Top module: `fine_scroll_shifter`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pix_valid` is 0, `pix_index` is 0 and `line_groups` is 0.
- R2: In four-plane mode the pixel driven in a cycle with `disp_en` high appears on `pix_index` one clock later. Index bit k comes from the plane-k word, held in `grp_data[16k+15:16k]`. Pixels of a group are taken from bit 15 downward.
- R3: With latched scroll s, pixel p of the line (counting only `disp_en` cycles since line start) shows bit 15-((p+s) mod 16) of group floor((p+s)/16), where groups are numbered in load order from 0. The first s pixels of group 0 never appear.
- R4: With s nonzero, the last s pixels of a line of ACTIVE_GROUPS×16 pixels come from group number ACTIVE_GROUPS. One cycle after `line_start`, `line_groups` equals ACTIVE_GROUPS+1 when s is nonzero and ACTIVE_GROUPS when s is zero.
- R5: With s = 0 the output equals the unscrolled picture. The group loaded after the last visible group has no effect on any pixel.
- R6: In one-plane mode (`mono_mode` = 1 at line start), `pix_index` is {3'b000, b}, where b comes from word 0 alone. Words 1 to 3 have no effect.
- R7: `scroll_in` and `mono_mode` are sampled only in the `line_start` cycle. Changes to them during the line have no effect on that line.
- R8: One clock after a cycle with `disp_en` low, `pix_valid` is 0 and `pix_index` is 0. The pixel position does not advance during such cycles, so the line resumes where it stopped.
- R9: The first two `grp_load` pulses after `line_start` fill the window. A later load is used from the next 16-pixel boundary onward. A load in the very cycle of the boundary pixel (position 16k+15) is passed straight into the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that begins a line and samples scroll and mode |
| scroll_in | input | 4 | Pixel scroll amount 0..15 |
| mono_mode | input | 1 | 1 = one-plane mode, 0 = four-plane mode |
| grp_load | input | 1 | A fetch group is present on `grp_data` |
| grp_data | input | 64 | Fetch group, plane k in bits [16k+15:16k] |
| disp_en | input | 1 | Active display; one pixel per cycle when high |
| pix_valid | output | 1 | Registered pixel strobe |
| pix_index | output | 4 | Registered colour index, 0 during blanking |
| line_groups | output | 5 | Groups the current line consumes |

## Verification
`line_groups` settles one clock after `line_start`, so the bench reads it on the falling edge that follows the start pulse. Each pixel index and its strobe are due one clock after the cycle in which `disp_en` was driven for that pixel. The bench drives inputs on falling edges and, on every falling edge, first compares the result of the previous cycle against a reference pixel. The reference is computed directly from the group number and bit position in R3, not from a window. Blank cycles are checked on the same one-clock rule.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef enum logic {
    MODE_PLANAR4 = 1'b0,
    MODE_MONO    = 1'b1
  } shift_mode_e;

  // Per-cycle window commands issued by the line controller to every plane.
  typedef struct packed {
    logic clr;       // line start: empty the window
    logic prime;     // priming load: shift a new word in at the right
    logic stage_wr;  // early load parked until the next boundary
    logic adv;       // 16-pixel boundary: slide window by one word
    logic byp;       // load arrives on the boundary cycle itself
  } win_ctrl_t;

endpackage

// File: rtl/fss_line_ctrl.sv
module fss_line_ctrl
  import fss_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int ACTIVE_GROUPS = 20,
  localparam int SCR_W        = $clog2(WORD_W),
  localparam int GRP_W        = $clog2(ACTIVE_GROUPS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [SCR_W-1:0] scroll_in,
  input  logic             mono_in,
  input  logic             grp_load,
  input  logic             disp_en,
  output win_ctrl_t        ctrl,
  output logic [SCR_W:0]   offset,
  output shift_mode_e      mode_lat,
  output logic [GRP_W-1:0] line_groups
);

  localparam logic [1:0]       PRIMED    = 2'd2;
  localparam logic [SCR_W-1:0] LAST_PHASE = SCR_W'(WORD_W - 1);

  logic [1:0]       fill;
  logic [SCR_W-1:0] phase;
  logic [SCR_W-1:0] scroll_lat;

  always_comb begin
    ctrl          = '0;
    ctrl.clr      = line_start;
    ctrl.prime    = !line_start && grp_load && (fill != PRIMED);
    ctrl.adv      = !line_start && disp_en && (phase == LAST_PHASE);
    ctrl.byp      = ctrl.adv && grp_load && (fill == PRIMED);
    ctrl.stage_wr = !line_start && grp_load && (fill == PRIMED) && !ctrl.adv;
  end

  assign offset = {1'b0, phase} + {1'b0, scroll_lat};

  always_ff @(posedge clk) begin
    if (rst) begin
      fill        <= '0;
      phase       <= '0;
      scroll_lat  <= '0;
      mode_lat    <= MODE_PLANAR4;
      line_groups <= '0;
    end else if (line_start) begin
      fill        <= '0;
      phase       <= '0;
      scroll_lat  <= scroll_in;
      mode_lat    <= mono_in ? MODE_MONO : MODE_PLANAR4;
      line_groups <= GRP_W'(ACTIVE_GROUPS) + GRP_W'(scroll_in != '0);
    end else begin
      if (ctrl.prime) fill <= fill + 2'd1;
      if (disp_en) phase <= phase + 1'b1;
    end
  end

  assert_scroll_held_R7: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> ($stable(scroll_lat) && $stable(mode_lat)));

  assert_line_restart_R9: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (phase == '0 && fill == '0));

  assert_group_count_R4: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (line_groups ==
                    GRP_W'(ACTIVE_GROUPS) + GRP_W'($past(scroll_in) != '0)));

endmodule

// File: rtl/fss_plane_window.sv
module fss_plane_window
  import fss_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  win_ctrl_t           ctrl,
  input  logic [WORD_W-1:0]   din,
  output logic [2*WORD_W-1:0] win
);

  logic [WORD_W-1:0] cur;
  logic [WORD_W-1:0] nxt;
  logic [WORD_W-1:0] stage;

  assign win = {cur, nxt};

  always_ff @(posedge clk) begin
    if (rst || ctrl.clr) begin
      cur   <= '0;
      nxt   <= '0;
      stage <= '0;
    end else if (ctrl.prime) begin
      cur <= nxt;
      nxt <= din;
    end else if (ctrl.adv) begin
      cur   <= nxt;
      nxt   <= ctrl.byp ? din : stage;
      stage <= '0;
    end else if (ctrl.stage_wr) begin
      stage <= din;
    end
  end

  assert_window_slide_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl.adv && !ctrl.clr && !ctrl.prime) |=> (cur == $past(nxt)));

  assert_window_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.clr |=> (cur == '0 && nxt == '0));

endmodule

// File: rtl/fss_pixel_out.sv
module fss_pixel_out
  import fss_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int WORD_W  = 16,
  localparam int SCR_W  = $clog2(WORD_W)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NPLANES-1:0][2*WORD_W-1:0]      windows,
  input  logic [SCR_W:0]                        offset,
  input  shift_mode_e                           mode,
  input  logic                                  disp_en,
  output logic                                  pix_valid,
  output logic [NPLANES-1:0]                    pix_index
);

  localparam logic [SCR_W:0] TOP_BIT = (SCR_W+1)'(2*WORD_W - 1);

  logic [SCR_W:0]      sel;
  logic [NPLANES-1:0]  raw_bits;
  logic [NPLANES-1:0]  idx;

  assign sel = TOP_BIT - offset;

  for (genvar k = 0; k < NPLANES; k++) begin : g_pick
    assign raw_bits[k] = windows[k][sel];
  end

  always_comb begin
    if (mode == MODE_MONO) idx = {{(NPLANES-1){1'b0}}, raw_bits[0]};
    else                   idx = raw_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_index <= '0;
    end else begin
      pix_valid <= disp_en;
      pix_index <= disp_en ? idx : '0;
    end
  end

  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> (!pix_valid && pix_index == '0));

  assert_pixel_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    disp_en |=> pix_valid);

  assert_mono_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (disp_en && mode == MODE_MONO) |=> (pix_index[NPLANES-1:1] == '0));

endmodule

// File: rtl/fine_scroll_shifter.sv
module fine_scroll_shifter
  import fss_pkg::*;
#(
  parameter int NPLANES       = 4,
  parameter int WORD_W        = 16,
  parameter int ACTIVE_GROUPS = 20,
  localparam int SCR_W        = $clog2(WORD_W),
  localparam int GRP_W        = $clog2(ACTIVE_GROUPS + 2)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      line_start,
  input  logic [SCR_W-1:0]          scroll_in,
  input  logic                      mono_mode,
  input  logic                      grp_load,
  input  logic [NPLANES*WORD_W-1:0] grp_data,
  input  logic                      disp_en,
  output logic                      pix_valid,
  output logic [NPLANES-1:0]        pix_index,
  output logic [GRP_W-1:0]          line_groups
);

  win_ctrl_t                         ctrl;
  logic [SCR_W:0]                    offset;
  shift_mode_e                       mode_lat;
  logic [NPLANES-1:0][2*WORD_W-1:0]  windows;

  fss_line_ctrl #(
    .WORD_W        (WORD_W),
    .ACTIVE_GROUPS (ACTIVE_GROUPS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .scroll_in   (scroll_in),
    .mono_in     (mono_mode),
    .grp_load    (grp_load),
    .disp_en     (disp_en),
    .ctrl        (ctrl),
    .offset      (offset),
    .mode_lat    (mode_lat),
    .line_groups (line_groups)
  );

  for (genvar k = 0; k < NPLANES; k++) begin : g_plane
    fss_plane_window #(
      .WORD_W (WORD_W)
    ) u_win (
      .clk  (clk),
      .rst  (rst),
      .ctrl (ctrl),
      .din  (grp_data[k*WORD_W +: WORD_W]),
      .win  (windows[k])
    );
  end

  fss_pixel_out #(
    .NPLANES (NPLANES),
    .WORD_W  (WORD_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .windows   (windows),
    .offset    (offset),
    .mode      (mode_lat),
    .disp_en   (disp_en),
    .pix_valid (pix_valid),
    .pix_index (pix_index)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pix_valid && pix_index == '0 && line_groups == '0));

endmodule

// File: tb/fine_scroll_shifter_tb.sv
module fine_scroll_shifter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPL        = 4;
  localparam int WW         = 16;
  localparam int AG         = 3;
  localparam int NPIX       = AG * WW;
  localparam int GW         = $clog2(AG + 2);

  typedef struct packed {
    logic [3:0]  scroll;
    logic        mono;
    logic        byp;
    logic        gap;
    logic        mid;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3},
    '{4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 16'h1E2D},
    '{4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 16'h7B40},
    '{4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 16'h3C99},
    '{4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 16'hD00F},
    '{4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 16'h5AA6},
    '{4'd5,  1'b0, 1'b0, 1'b1, 1'b0, 16'hC731},
    '{4'd12, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0BE8},
    '{4'd0,  1'b0, 1'b1, 1'b1, 1'b0, 16'h9146}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            line_start = 1'b0;
  logic [3:0]      scroll_in = '0;
  logic            mono_mode = 1'b0;
  logic            grp_load = 1'b0;
  logic [NPL*WW-1:0] grp_data = '0;
  logic            disp_en = 1'b0;
  logic            pix_valid;
  logic [NPL-1:0]  pix_index;
  logic [GW-1:0]   line_groups;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fine_scroll_shifter #(
    .NPLANES       (NPL),
    .WORD_W        (WW),
    .ACTIVE_GROUPS (AG)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .scroll_in   (scroll_in),
    .mono_mode   (mono_mode),
    .grp_load    (grp_load),
    .grp_data    (grp_data),
    .disp_en     (disp_en),
    .pix_valid   (pix_valid),
    .pix_index   (pix_index),
    .line_groups (line_groups)
  );

  function automatic logic [15:0] plane_word(logic [15:0] seed, int g, int k);
    return seed ^ (16'(g) * 16'h3C5B) ^ (16'(k) * 16'h9A17) ^ {8'(g), 8'(k * 37)};
  endfunction

  function automatic logic [NPL*WW-1:0] group_data(logic [15:0] seed, int g);
    logic [NPL*WW-1:0] d;
    for (int k = 0; k < NPL; k++) d[k*WW +: WW] = plane_word(seed, g, k);
    return d;
  endfunction

  // Reference pixel straight from group number and bit position.
  function automatic logic [3:0] ref_pix(logic [15:0] seed, int s, bit mono, int p);
    int b = p + s;
    int g = b / WW;
    int o = b % WW;
    logic [3:0] r = '0;
    for (int k = 0; k < NPL; k++) begin
      logic [15:0] w = plane_word(seed, g, k);
      if (!mono || k == 0) r[k] = w[15 - o];
    end
    return r;
  endfunction

  function automatic string tag_for(vec_t v, int p);
    if (v.mid)                            return "R7";
    if (v.mono)                           return "R6";
    if (v.byp)                            return "R9";
    if (v.scroll != 0 && p >= NPIX - int'(v.scroll)) return "R4";
    if (v.scroll != 0)                    return "R3";
    if (p >= 2 * WW)                      return "R5";
    return "R2";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp, string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_prev(vec_t v, int prev);
    logic [3:0] e;
    if (prev < 0) begin
      chk(!pix_valid && pix_index == 0, "R8", {pix_valid, pix_index}, 0, "blank cycle");
    end else begin
      e = ref_pix(v.seed, int'(v.scroll), v.mono, prev);
      chk(pix_valid && pix_index == e, tag_for(v, prev),
          {pix_valid, pix_index}, {1'b1, e}, $sformatf("pixel %0d", prev));
    end
  endtask

  task automatic run_line(vec_t v);
    int p = 0;
    int prev = -1;
    int gcnt = 0;
    int load_at = v.byp ? WW - 1 : 5;
    @(negedge clk);
    line_start = 1'b1; scroll_in = v.scroll; mono_mode = v.mono;
    @(negedge clk);
    line_start = 1'b0;
    chk(line_groups == GW'(AG + (v.scroll != 0 ? 1 : 0)), "R4",
        line_groups, AG + (v.scroll != 0 ? 1 : 0), "line_groups");
    grp_load = 1'b1; grp_data = group_data(v.seed, 0);
    @(negedge clk);
    grp_data = group_data(v.seed, 1);
    @(negedge clk);
    grp_load = 1'b0; grp_data = '0;
    if (v.mid) begin
      scroll_in = ~v.scroll; mono_mode = ~v.mono;
    end
    while (p < NPIX) begin
      @(negedge clk);
      check_prev(v, prev);
      grp_load = 1'b0;
      if (v.gap && p == 20 && gcnt < 3) begin
        disp_en = 1'b0;
        prev = -1;
        gcnt++;
      end else begin
        disp_en = 1'b1;
        if ((p % WW) == load_at && (p / WW + 2) <= AG) begin
          grp_load = 1'b1;
          grp_data = group_data(v.seed, p / WW + 2);
        end
        prev = p;
        p++;
      end
    end
    @(negedge clk);
    check_prev(v, prev);
    disp_en = 1'b0; grp_load = 1'b0;
    @(negedge clk);
    check_prev(v, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pix_valid && pix_index == 0 && line_groups == 0, "R1",
        {line_groups, pix_valid, pix_index}, 0, "reset state");
    rst = 1'b0;
    @(negedge clk);
    chk(!pix_valid && pix_index == 0 && line_groups == 0, "R1",
        {line_groups, pix_valid, pix_index}, 0, "after release");

    for (int i = 0; i < NVEC; i++) run_line(VECS[i]);

    // Mid-line reset returns every output to its idle value.
    @(negedge clk);
    line_start = 1'b1; scroll_in = 4'd3;
    @(negedge clk);
    line_start = 1'b0; grp_load = 1'b1; grp_data = {4{16'hFFFF}};
    @(negedge clk);
    @(negedge clk);
    grp_load = 1'b0; disp_en = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b1, "R2", pix_valid, 1, "strobe before reset");
    rst = 1'b1;
    @(negedge clk);
    chk(!pix_valid && pix_index == 0 && line_groups == 0, "R1",
        {line_groups, pix_valid, pix_index}, 0, "mid-line reset");
    disp_en = 1'b0; rst = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule